// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

The block keeps a 7-bit count that advances once for each overflow pulse from an upstream prescaler. The count is not tied to the system clock rate. Software writes a 7-bit compare value. When the next step would bring the count equal to that value, the block registers a match and the count returns to zero. The time between matches is therefore the compare value multiplied by the prescaler's overflow interval.

A mode bit in the control register decides what a match does.

- **Interval-timer mode:** a match sets a sticky interrupt flag and counting continues.
- **Watchdog mode:** a match starts a fixed-length active-low reset request. If the system is running from its sub clock at that moment, the block also raises a request to turn the main oscillator back on for the length of the pulse.

While the reset pulse is active, every register in the block is held at its reset value. The counter freezes while the STOP input is high and resumes on its own when STOP falls.

Top module: `wdt_interval_timer`

## Requirements
- R1: After rst_ni, the outputs are rst_req_no=1, irq_o=0, cnt_o=0 and main_osc_on_o=0. Watchdog mode is off and the compare value is 7Fh.
- R2: cnt_o increments by one on each clock edge where tick_i=1 and stop_i=0. It never increments on any other edge.
- R3: A match occurs on the tick that would bring the count to the compare value. On that tick the count returns to 0, so matches come every compare-value ticks. A compare value of 0 gives 128 ticks.
- R4: In interval-timer mode (control bit 0 = 0), a match sets irq_o on the same edge that clears the count, and rst_req_no stays 1.
- R5: irq_o stays set until a control write (wr_sel_i=0) with bit 1 = 1 clears it. If a match and such a clear fall on the same edge, irq_o ends up set.
- R6: In watchdog mode (control bit 0 = 1), a match drives rst_req_no low for exactly RST_LEN clocks, starting at the match edge, and irq_o does not rise.
- R7: When rst_req_no returns high, watchdog mode is off, the compare value is 7Fh, and both the count and irq_o are 0.
- R8: A compare write (wr_sel_i=1) loads bits 6:0 as the compare value. If bit 7 = 1, the same write clears the count, and the clear wins over a tick on the same edge.
- R9: While stop_i=1, cnt_o holds its value. Counting resumes from that value after stop_i falls.
- R10: During a reset pulse, main_osc_on_o equals the value sub_clk_i had on the match edge. Outside a pulse, main_osc_on_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the control register, 1 selects the compare register |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 1 | Prescaler overflow pulse |
| stop_i | input | 1 | STOP mode; freezes the counter |
| sub_clk_i | input | 1 | System is running from the sub clock |
| cnt_o | output | 7 | Current count |
| irq_o | output | 1 | Sticky interval interrupt flag |
| rst_req_no | output | 1 | Active-low reset request |
| main_osc_on_o | output | 1 | Main oscillator re-enable request |

## Verification
The hardest state to reach is the return from a watchdog pulse. Software has no way to clear the mode bit at that point, so the only proof that it fell back to zero is behaviour.

The bench lets a watchdog match fire and counts the low cycles of the reset request. It then gives 127 further ticks with no register writes. Those ticks must end in an interrupt, not a second reset. That outcome shows the mode bit, the compare value and the count all came back to their reset values.

Same-edge collisions are also driven on purpose: a counter clear with a tick, and an interrupt clear with a match.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 7;
  typedef logic [CNT_W-1:0] cnt_t;
  // control register bit positions
  localparam int CTL_WD_EN  = 0;
  localparam int CTL_IRQ_CL = 1;
  // compare register clear bit
  localparam int CMP_CLR    = 7;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter cnt_t CMP_RST = 7'h7F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       irq_set_i,
  output logic       wd_en_o,
  output cnt_t       cmp_o,
  output logic       clr_o,
  output logic       irq_o
);
  logic wr_ok;
  logic ctl_wr;
  logic cmp_wr;

  assign wr_ok  = wr_en_i & ~srst_i;
  assign ctl_wr = wr_ok & ~wr_sel_i;
  assign cmp_wr = wr_ok & wr_sel_i;
  assign clr_o  = cmp_wr & wr_data_i[CMP_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_en_o <= 1'b0;
      cmp_o   <= CMP_RST;
    end else if (srst_i) begin
      wd_en_o <= 1'b0;
      cmp_o   <= CMP_RST;
    end else begin
      if (ctl_wr) wd_en_o <= wr_data_i[CTL_WD_EN];
      if (cmp_wr) cmp_o   <= wr_data_i[CNT_W-1:0];
    end
  end

  // a set on the same edge as a clear wins, so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
    end else if (srst_i) begin
      irq_o <= 1'b0;
    end else if (irq_set_i) begin
      irq_o <= 1'b1;
    end else if (ctl_wr && wr_data_i[CTL_IRQ_CL]) begin
      irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic tick_i,
  input  logic stop_i,
  input  logic clr_i,
  input  cnt_t cmp_i,
  output cnt_t cnt_o,
  output logic match_o
);
  cnt_t cnt_q;
  cnt_t cnt_inc;
  logic step;

  assign step    = tick_i & ~stop_i & ~srst_i & ~clr_i;
  assign cnt_inc = cnt_q + CNT_W'(1);
  // 7-bit wrap makes a compare value of 0 match after 128 ticks
  assign match_o = step & (cnt_inc == cmp_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (srst_i || clr_i || match_o) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/wdt_rst_gen.sv
module wdt_rst_gen #(
  parameter int RST_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic sub_clk_i,
  output logic active_o,
  output logic rst_req_no,
  output logic osc_on_o
);
  localparam int PW = $clog2(RST_LEN + 1);

  logic [PW-1:0] left_q;
  logic          osc_q;

  assign active_o   = (left_q != '0);
  assign rst_req_no = ~active_o;
  assign osc_on_o   = osc_q & active_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      osc_q  <= 1'b0;
    end else if (active_o) begin
      left_q <= left_q - PW'(1);
    end else if (trig_i) begin
      left_q <= PW'(RST_LEN);
      osc_q  <= sub_clk_i;
    end else begin
      osc_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer
  import wdt_pkg::*;
#(
  parameter int   RST_LEN = 4,
  parameter cnt_t CMP_RST = 7'h7F
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [7:0]   wr_data_i,
  input  logic         tick_i,
  input  logic         stop_i,
  input  logic         sub_clk_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic         irq_o,
  output logic         rst_req_no,
  output logic         main_osc_on_o
);
  logic wd_en;
  cnt_t cmp;
  logic clr;
  logic match;
  logic pulse_on;

  wdt_regs #(.CMP_RST(CMP_RST)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (pulse_on),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .irq_set_i (match & ~wd_en),
    .wd_en_o   (wd_en),
    .cmp_o     (cmp),
    .clr_o     (clr),
    .irq_o     (irq_o)
  );

  wdt_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (pulse_on),
    .tick_i  (tick_i),
    .stop_i  (stop_i),
    .clr_i   (clr),
    .cmp_i   (cmp),
    .cnt_o   (cnt_o),
    .match_o (match)
  );

  wdt_rst_gen #(.RST_LEN(RST_LEN)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (match & wd_en),
    .sub_clk_i  (sub_clk_i),
    .active_o   (pulse_on),
    .rst_req_no (rst_req_no),
    .osc_on_o   (main_osc_on_o)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int RST_LEN = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic       stop_i,
  input logic       sub_clk_i,
  input cnt_t       cnt_o,
  input logic       irq_o,
  input logic       rst_req_no,
  input logic       main_osc_on_o,
  input logic       wd_en
);
  localparam int LW = $clog2(RST_LEN + 2);
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt <= '0;
    else if (!rst_req_no) begin
      if (low_cnt <= LW'(RST_LEN)) low_cnt <= low_cnt + LW'(1);
    end else low_cnt <= '0;
  end

  // R6
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt <= LW'(RST_LEN));

  // R4
  irq_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$past(wd_en));

  // R7
  pulse_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_no) |-> (!wd_en && cnt_o == '0 && !irq_o));

  // R8
  clr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && wr_data_i[CMP_CLR]) |=> cnt_o == '0);

  // R9
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !(wr_en_i && wr_sel_i && wr_data_i[CMP_CLR])) |=> $stable(cnt_o));

  // R10
  osc_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_no) |-> main_osc_on_o == $past(sub_clk_i));

  // R10
  osc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_no |-> !main_osc_on_o);
endmodule

bind wdt_interval_timer wdt_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_sel_i      (wr_sel_i),
  .wr_data_i     (wr_data_i),
  .stop_i        (stop_i),
  .sub_clk_i     (sub_clk_i),
  .cnt_o         (cnt_o),
  .irq_o         (irq_o),
  .rst_req_no    (rst_req_no),
  .main_osc_on_o (main_osc_on_o),
  .wd_en         (wd_en)
);

// File: tb/sim_wdt_interval_timer.sv
module sim_wdt_interval_timer;
  localparam int RST_LEN = 4;
  localparam int NV = 5;
  localparam logic [6:0] VEC_CMP [NV] = '{7'd1, 7'd2, 7'd5, 7'd64, 7'd0};
  localparam int         VEC_TCK [NV] = '{1, 2, 5, 64, 128};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       tick_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       sub_clk_i = 1'b0;
  logic [6:0] cnt_o;
  logic       irq_o;
  logic       rst_req_no;
  logic       main_osc_on_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  wdt_interval_timer #(.RST_LEN(RST_LEN)) u0 (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .tick_i, .stop_i,
    .sub_clk_i, .cnt_o, .irq_o, .rst_req_no, .main_osc_on_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic wd_fire(input logic sub);
    int low = 0;
    sub_clk_i = sub;
    wr(1'b1, 8'h83);
    wr(1'b0, 8'h01);
    tick(); tick();
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    sub_clk_i = ~sub;
    chk("R6 reset asserted", rst_req_no, 0);
    chk("R6 no irq in watchdog mode", irq_o, 0);
    chk("R10 osc request", main_osc_on_o, sub);
    for (int i = 0; i < 20; i++) begin
      if (!rst_req_no) low++;
      @(negedge clk_i);
    end
    chk("R6 pulse length", low, RST_LEN);
    chk("R10 osc idle after pulse", main_osc_on_o, 0);
    chk("R7 count cleared", cnt_o, 0);
    chk("R7 irq cleared", irq_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1 rst_req_no", rst_req_no, 1);
    chk("R1 irq", irq_o, 0);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 osc", main_osc_on_o, 0);

    // R3 R4: periods from the vector table
    for (int v = 0; v < NV; v++) begin
      wr(1'b1, 8'h80 | {1'b0, VEC_CMP[v]});
      wr(1'b0, 8'h02);
      for (int t = 0; t < VEC_TCK[v] - 1; t++) tick();
      chk("R3 no early match", irq_o, 0);
      tick();
      chk("R4 irq on match", irq_o, 1);
      chk("R3 count wraps to 0", cnt_o, 0);
      chk("R4 no reset in timer mode", rst_req_no, 1);
    end

    // R5: sticky until cleared
    repeat (10) @(negedge clk_i);
    chk("R5 irq held", irq_o, 1);
    wr(1'b0, 8'h02);
    chk("R5 irq cleared", irq_o, 0);

    // R2: only ticks advance
    wr(1'b1, 8'h80 | 8'd10);
    repeat (6) @(negedge clk_i);
    chk("R2 idle clocks", cnt_o, 0);
    tick(); tick(); tick();
    chk("R2 three ticks", cnt_o, 3);

    // R9: stop freezes
    stop_i = 1'b1;
    tick(); tick(); tick();
    chk("R9 held in stop", cnt_o, 3);
    stop_i = 1'b0;
    tick();
    chk("R9 resumes", cnt_o, 4);

    // R8: clear beats tick; lower bits load compare
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 8'h83;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    chk("R8 clear wins over tick", cnt_o, 0);
    tick(); tick();
    chk("R8 compare 3 not yet", irq_o, 0);
    tick();
    chk("R8 compare 3 loaded", irq_o, 1);

    // R5: set wins over same-edge clear
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h81);
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 8'h02;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    chk("R5 set wins over clear", irq_o, 1);
    wr(1'b0, 8'h02);

    // R6 R7 R10 watchdog from sub clock
    wd_fire(1'b1);
    // R7: mode and compare back to defaults -> 127 ticks give irq, not reset
    for (int t = 0; t < 126; t++) tick();
    chk("R7 default compare not yet", irq_o, 0);
    tick();
    chk("R7 timer mode after pulse", irq_o, 1);
    chk("R7 no second reset", rst_req_no, 1);
    wr(1'b0, 8'h02);

    // R10 watchdog from main clock
    wd_fire(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule